// File: doc/BRIEF.md
# Program-Counter Window Trigger

This block watches the stream of retired instruction addresses and raises a stop-trigger event for a trace controller when an address falls into, or leaves, a programmed window. The window is an aligned power-of-two region: a trigger address is compared with the current program counter after a programmable number of low bits is discarded from both. A sense input chooses whether the event fires for an address inside the region or for one outside it.

The comparator is armed while its enable input is high. On the first qualifying instruction after arming it emits a registered one-cycle pulse and moves to a fired state. It stays there, silent, until the enable drops or the trace enable falls. Alongside the pulse, a sticky cause flag records that the stop came from this comparator. The flag is cleared only by a falling edge on the trace-enable input.

The control is a three-state machine. `ST_IDLE` moves to `ST_ARMED` when the enable is high. `ST_ARMED` returns to `ST_IDLE` when the enable drops, and moves to `ST_FIRED` on a qualifying instruction. `ST_FIRED` returns to `ST_IDLE` when the enable drops or the trace enable falls.

Top module: `pcm_trigger_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `match_pulse` and `cause_flag` are 0.
- R2: With an ignore count of 0 and sense 0, only a program counter equal in every bit to `trig_addr` qualifies.
- R3: With an ignore count of n, the low n bits are excluded from the comparison, so every address in the aligned 2^n region that contains `trig_addr` qualifies (sense 0).
- R4: An ignore count of PC_W-1 or more compares only the top bit of the address.
- R5: With `sense_out` = 0, an address qualifies when it is inside the region; with `sense_out` = 1, it qualifies when it is outside.
- R6: A cycle with `pc_valid` low never produces a pulse, whatever the address.
- R7: While `match_en` is low no pulse is produced, and dropping it re-arms the comparator for a later enable.
- R8: `match_pulse` rises on the clock edge that samples the first qualifying instruction in `ST_ARMED`, lasts one cycle, and does not repeat until the comparator is re-armed.
- R9: `cause_flag` goes to 1 on the same edge as the pulse and stays 1 while `trace_en` does not fall.
- R10: A 1-to-0 transition of `trace_en` clears `cause_flag`, suppresses any pulse in that cycle, and sends `ST_FIRED` back to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | Instruction-valid strobe |
| pc_value | input | PC_W | Current program counter |
| trig_addr | input | PC_W | Programmed trigger address |
| ign_count | input | IGN_W | Number of low address bits to ignore |
| sense_out | input | 1 | 0: fire inside region, 1: fire outside region |
| match_en | input | 1 | Comparator enable (arms the machine) |
| trace_en | input | 1 | Trace enable; its falling edge clears the cause flag |
| match_pulse | output | 1 | Registered one-cycle stop-trigger event |
| cause_flag | output | 1 | Sticky flag: the stop came from an address match |

## Verification
The bench builds the block with PC_W = 16 and the default IGN_W = 5. An ignore count can then go well past the address width, so counts 15 through 31 all exercise the top-bit-only clamp. The narrow address also lets random program counters drawn near the trigger address hit masked regions of every size often.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } pcm_state_e;
endpackage

// File: rtl/pcm_mask_gen.sv
module pcm_mask_gen #(
    parameter int PC_W  = 32,
    parameter int IGN_W = 5
) (
    input  logic [IGN_W-1:0] ign_count,
    output logic [PC_W-1:0]  keep_mask
);
    localparam int MAX_SHIFT = PC_W - 1;

    logic [31:0] eff_shift;

    always_comb begin
        if (32'(ign_count) > 32'(MAX_SHIFT))
            eff_shift = 32'(MAX_SHIFT);
        else
            eff_shift = 32'(ign_count);
    end

    for (genvar i = 0; i < PC_W; i++) begin : g_bit
        assign keep_mask[i] = (32'(i) >= eff_shift);
    end
endmodule

// File: rtl/pcm_range_cmp.sv
module pcm_range_cmp #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc_value,
    input  logic [PC_W-1:0] trig_addr,
    input  logic [PC_W-1:0] keep_mask,
    input  logic            sense_out,
    output logic            qualify
);
    logic in_region;

    always_comb begin
        in_region = (((pc_value ^ trig_addr) & keep_mask) == '0);
        qualify   = in_region ^ sense_out;
    end
endmodule

// File: rtl/pcm_trigger_top.sv
module pcm_trigger_top
    import pcm_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IGN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_valid,
    input  logic [PC_W-1:0]  pc_value,
    input  logic [PC_W-1:0]  trig_addr,
    input  logic [IGN_W-1:0] ign_count,
    input  logic             sense_out,
    input  logic             match_en,
    input  logic             trace_en,
    output logic             match_pulse,
    output logic             cause_flag
);
    pcm_state_e state_q, state_d;

    logic [PC_W-1:0] keep_mask;
    logic            qualify;
    logic            trace_en_q;
    logic            trace_fall;
    logic            fire;

    pcm_mask_gen #(.PC_W(PC_W), .IGN_W(IGN_W)) u_mask (
        .ign_count (ign_count),
        .keep_mask (keep_mask)
    );

    pcm_range_cmp #(.PC_W(PC_W)) u_cmp (
        .pc_value  (pc_value),
        .trig_addr (trig_addr),
        .keep_mask (keep_mask),
        .sense_out (sense_out),
        .qualify   (qualify)
    );

    assign trace_fall = trace_en_q & ~trace_en;
    assign fire = (state_q == ST_ARMED) & match_en & pc_valid & qualify & ~trace_fall;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (match_en) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!match_en)  state_d = ST_IDLE;
                else if (fire)  state_d = ST_FIRED;
            end
            ST_FIRED: if (!match_en || trace_fall) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_pulse <= 1'b0;
            cause_flag  <= 1'b0;
            trace_en_q  <= 1'b0;
        end else begin
            trace_en_q  <= trace_en;
            match_pulse <= fire;
            if (trace_fall)  cause_flag <= 1'b0;
            else if (fire)   cause_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_trigger_chk.sv
module pcm_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic pc_valid,
    input logic match_en,
    input logic trace_en,
    input logic match_pulse,
    input logic cause_flag
);
    a_r6_no_pulse_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |=> !match_pulse);

    a_r7_no_pulse_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !match_en |=> !match_pulse);

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    a_r9_cause_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> cause_flag);

    a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_flag && trace_en) |=> cause_flag);

    a_r10_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trace_en) |=> (!cause_flag && !match_pulse));
endmodule

bind pcm_trigger_top pcm_trigger_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_valid    (pc_valid),
    .match_en    (match_en),
    .trace_en    (trace_en),
    .match_pulse (match_pulse),
    .cause_flag  (cause_flag)
);

// File: tb/sim_pcm_trigger_top.sv
module sim_pcm_trigger_top;
    localparam int PC_W  = 16;
    localparam int IGN_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pc_valid = 1'b0;
    logic [PC_W-1:0]  pc_value = '0;
    logic [PC_W-1:0]  trig_addr = '0;
    logic [IGN_W-1:0] ign_count = '0;
    logic             sense_out = 1'b0;
    logic             match_en = 1'b0;
    logic             trace_en = 1'b0;
    logic             match_pulse;
    logic             cause_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 armed, 2 fired
    int m_st = 0;
    bit m_tq = 1'b0;
    bit m_cause = 1'b0;
    bit m_pulse = 1'b0;

    always #10 clk = ~clk;

    pcm_trigger_top #(.PC_W(PC_W), .IGN_W(IGN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_value(pc_value),
        .trig_addr(trig_addr), .ign_count(ign_count), .sense_out(sense_out),
        .match_en(match_en), .trace_en(trace_en),
        .match_pulse(match_pulse), .cause_flag(cause_flag)
    );

    function automatic bit in_region(logic [PC_W-1:0] pc, logic [PC_W-1:0] ta,
                                     logic [IGN_W-1:0] ign);
        int sh;
        sh = (int'(ign) > PC_W - 1) ? PC_W - 1 : int'(ign);
        return ((pc ^ ta) >> sh) == '0;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, advance the model at the edge, check at the next negedge.
    task automatic cyc(string tag, bit v, logic [PC_W-1:0] pc, logic [PC_W-1:0] ta,
                       logic [IGN_W-1:0] ign, bit sn, bit en, bit te);
        bit fall, hit;
        pc_valid = v; pc_value = pc; trig_addr = ta; ign_count = ign;
        sense_out = sn; match_en = en; trace_en = te;
        @(posedge clk);
        fall = m_tq & ~te;
        hit  = v & (in_region(pc, ta, ign) ^ sn);
        m_pulse = (m_st == 1) & en & hit & ~fall;
        case (m_st)
            0: m_st = en ? 1 : 0;
            1: m_st = !en ? 0 : (m_pulse ? 2 : 1);
            default: m_st = (!en || fall) ? 0 : 2;
        endcase
        if (fall) m_cause = 1'b0;
        else if (m_pulse) m_cause = 1'b1;
        m_tq = te;
        @(negedge clk);
        check(tag, match_pulse, m_pulse, "match_pulse");
        check(tag, cause_flag, m_cause, "cause_flag");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        check("R1", match_pulse, 1'b0, "match_pulse in reset");
        check("R1", cause_flag, 1'b0, "cause_flag in reset");
        rst_n = 1'b1;
        cyc("R1", 0, 16'h0000, 16'h1234, 5'd0, 0, 0, 1);
        // R2: exact compare
        cyc("R2", 1, 16'h1234, 16'h1234, 5'd0, 0, 1, 1);
        cyc("R2", 1, 16'h1235, 16'h1234, 5'd0, 0, 1, 1);
        cyc("R2", 1, 16'h1234, 16'h1234, 5'd0, 0, 1, 1);
        // R8: no repeat while fired
        cyc("R8", 1, 16'h1234, 16'h1234, 5'd0, 0, 1, 1);
        // R9: cause sticky
        cyc("R9", 0, 16'h0000, 16'h1234, 5'd0, 0, 1, 1);
        // R10: trace fall clears and re-arms
        cyc("R10", 1, 16'h1234, 16'h1234, 5'd0, 0, 1, 0);
        cyc("R10", 0, 16'h0000, 16'h1234, 5'd0, 0, 1, 1);
        // R3: low 4 bits ignored
        cyc("R3", 1, 16'h1240, 16'h1230, 5'd4, 0, 1, 1);
        cyc("R3", 1, 16'h123F, 16'h1230, 5'd4, 0, 1, 1);
        // R7: disable then re-arm
        cyc("R7", 1, 16'h1230, 16'h1230, 5'd4, 0, 0, 1);
        cyc("R7", 1, 16'h1230, 16'h1230, 5'd4, 0, 0, 1);
        cyc("R7", 0, 16'h1230, 16'h1230, 5'd4, 0, 1, 1);
        // R6: invalid instruction ignored
        cyc("R6", 0, 16'h1230, 16'h1230, 5'd4, 0, 1, 1);
        // R4: clamp compares top bit only
        cyc("R4", 1, 16'h7FFF, 16'h8000, 5'd31, 0, 1, 1);
        cyc("R4", 1, 16'hFFFF, 16'h8000, 5'd20, 0, 1, 1);
        cyc("R4", 0, 16'h0000, 16'h8000, 5'd0, 0, 0, 1);
        // R5: outside-sense
        cyc("R5", 0, 16'h0000, 16'h4000, 5'd8, 1, 1, 1);
        cyc("R5", 1, 16'h40AB, 16'h4000, 5'd8, 1, 1, 1);
        cyc("R5", 1, 16'h4100, 16'h4000, 5'd8, 1, 1, 1);
        // random mix: R3 R5 R8 R9 R10 against the model
        for (int i = 0; i < 4000; i++) begin
            logic [PC_W-1:0] ta, pc;
            logic [IGN_W-1:0] ign;
            ta  = PC_W'($urandom);
            ign = IGN_W'($urandom_range(0, 31));
            pc  = ($urandom_range(0, 3) != 0) ? (ta ^ PC_W'($urandom_range(0, 63))) : PC_W'($urandom);
            cyc("R8", $urandom_range(0, 3) != 0, pc, ta, ign, $urandom_range(0, 4) == 0,
                $urandom_range(0, 9) != 0, $urandom_range(0, 15) != 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule